// File: doc/BRIEF.md
# Sixteen-Pin GPIO Port with Masked Output Writes and a Shared Interrupt

This block is a 16-pin general-purpose I/O port on a simple register bus. Software sets each pin's direction and writes output levels through a store that carries its own per-pin write mask. A single store can therefore change any subset of pins without reading the output register first. Pin levels pass through a two-flop synchroniser before software can read them.

The upper eight pins also drive one shared, active-high interrupt request. Each of these pins is gated by its own enable bit, and the gated results are ORed together. A build parameter chooses where the enable bits for those pins sit in the interrupt-enable register.

A block-control register holds a clock-enable bit and a soft-reset bit. The port does nothing until software enables it. The usual bring-up is to write 3 and then 1. Writing 2 parks the port in reset with its clock stopped.

Top module: `gpio16_port`

## Requirements
- R1: After `rst`, every register is zero: `pad_oe`, `pad_out`, `irq_shared` and `bus_rdata` are 0, and the block-control register reads 0, which means the clock is disabled.
- R2: A write to offset 0x08 uses `bus_wdata[31:16]` as a per-pin mask and `bus_wdata[15:0]` as values. A pin whose mask bit is 1 takes its new value on `pad_out` after the write edge, and every other pin keeps its level.
- R3: The direction register at offset 0x00 drives `pad_oe`, where bit n = 1 makes pin n an output and 0 makes it an input. The register reads back at 0x00.
- R4: A read of offset 0x0C returns in bits 15:0 the pin levels that `pad_in` had two clock edges before the read edge. The rest of `bus_rdata` is 0.
- R5: After an edge, `irq_shared` is 1 exactly when the clock is enabled and, for some pin n in 8..15, the synchronised level of that pin and its enable bit are both 1. With the default build, the enable bit for pin n is bit n of the interrupt-enable register at offset 0x10.
- R6: With `ENABLE_AT_ZERO = 1`, the enable bit for pin n (8..15) is bit n-8 of the interrupt-enable register, and bits 15:8 do not take part in the request.
- R7: The block-control register at offset 0x14 reads back in bits 1:0. Bit 0 is the clock enable and bit 1 is the soft reset. The sequence 3 then 1 leaves the port usable.
- R8: On every edge where the soft-reset bit is 1, the direction, output and interrupt-enable registers become zero and writes to them are lost. All pins are then inputs.
- R9: While the clock-enable bit is 0, writes to offsets 0x00, 0x08 and 0x10 change nothing, the pin-state read returns 0 and `irq_shared` is 0.
- R10: A read of the write-only offset 0x08, or of any unmapped offset, returns 0. `bus_rdata` is 0 in every cycle that follows an edge without a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one store per cycle |
| bus_rd | input | 1 | Read strobe; data appears after the edge |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pad_in | input | 16 | Asynchronous pin levels |
| pad_out | output | 16 | Output levels |
| pad_oe | output | 16 | Output enables, 1 = drive |
| irq_shared | output | 1 | Shared interrupt request of pins 8..15 |

## Verification
The hardest case to reach is where the block-control state and a register store meet on the same edge. This covers a direction store landing while the soft reset is still set, and stores while the clock is stopped, which must leave no trace once the port is enabled again. The stimulus drives such stores in those windows. It then reads the registers back after bring-up, so that a lost or leaked write shows at `bus_rdata` and on `pad_oe`. A second instance built with the alternate enable layout runs the same stimulus. This proves that only the selected half of the enable register gates the shared request.

// File: rtl/gpio16_pkg.sv
package gpio16_pkg;
  localparam int BUS_W  = 32;
  localparam int ADDR_W = 5;

  typedef enum logic [ADDR_W-1:0] {
    OFS_DIR = 5'h00,
    OFS_OUT = 5'h08,
    OFS_PIN = 5'h0C,
    OFS_IEN = 5'h10,
    OFS_CTL = 5'h14
  } reg_ofs_e;

  typedef struct packed {
    logic srst;
    logic clken;
  } ctl_t;
endpackage

// File: rtl/gpio16_sync.sv
module gpio16_sync #(
  parameter int W      = 16,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) st[i] <= '0;
    end else begin
      st[0] <= d;
      for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/gpio16_irq.sv
module gpio16_irq #(
  parameter int NSH = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           clken,
  input  logic [NSH-1:0] pins,
  input  logic [NSH-1:0] en,
  output logic           irq
);
  logic [NSH-1:0] hit;

  for (genvar g = 0; g < NSH; g++) begin : g_and
    assign hit[g] = pins[g] & en[g];
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= clken & (|hit);
  end

  // R5
  irq_gated_chk: assert property (@(posedge clk) disable iff (rst)
    !clken |=> !irq);
endmodule

// File: rtl/gpio16_regs.sv
module gpio16_regs
  import gpio16_pkg::*;
#(
  parameter int NPINS = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BUS_W-1:0]  wdata,
  input  logic [NPINS-1:0]  pin_sync,
  output logic [NPINS-1:0]  dir_q,
  output logic [NPINS-1:0]  out_q,
  output logic [NPINS-1:0]  ien_q,
  output logic              clken,
  output logic [BUS_W-1:0]  rdata_q
);
  localparam int MASK_LSB = BUS_W / 2;
  localparam int PAD_W    = BUS_W - NPINS;

  ctl_t ctl_q;
  logic [NPINS-1:0] wmask, wval;
  logic [BUS_W-1:0] rd_mux;

  assign wmask = wdata[MASK_LSB +: NPINS];
  assign wval  = wdata[NPINS-1:0];
  assign clken = ctl_q.clken;

  always_comb begin
    case (addr)
      OFS_DIR: rd_mux = {{PAD_W{1'b0}}, dir_q};
      OFS_PIN: rd_mux = {{PAD_W{1'b0}}, (ctl_q.clken ? pin_sync : '0)};
      OFS_IEN: rd_mux = {{PAD_W{1'b0}}, ien_q};
      OFS_CTL: rd_mux = {{(BUS_W-2){1'b0}}, ctl_q};
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q   <= '0;
      dir_q   <= '0;
      out_q   <= '0;
      ien_q   <= '0;
      rdata_q <= '0;
    end else begin
      if (wr_en && addr == OFS_CTL) ctl_q <= ctl_t'(wdata[1:0]);
      if (ctl_q.srst) begin
        dir_q <= '0;
        out_q <= '0;
        ien_q <= '0;
      end else if (ctl_q.clken && wr_en) begin
        case (addr)
          OFS_DIR: dir_q <= wval;
          OFS_OUT: out_q <= (out_q & ~wmask) | (wval & wmask);
          OFS_IEN: ien_q <= wval;
          default: ;
        endcase
      end
      rdata_q <= rd_en ? rd_mux : '0;
    end
  end

  // R8
  srst_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ctl_q.srst |=> (dir_q == '0 && out_q == '0 && ien_q == '0));

  // R9
  gated_write_chk: assert property (@(posedge clk) disable iff (rst)
    (!ctl_q.clken && !ctl_q.srst) |=> ($stable(dir_q) && $stable(out_q) && $stable(ien_q)));

  // R2
  mask_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == OFS_OUT && ctl_q.clken && !ctl_q.srst) |=>
      ((out_q & ~$past(wmask)) == ($past(out_q) & ~$past(wmask))));

  // R10
  wo_read_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == OFS_OUT) |=> rdata_q == '0);
endmodule

// File: rtl/gpio16_port.sv
module gpio16_port
  import gpio16_pkg::*;
#(
  parameter int NPINS          = 16,
  parameter int SYNC_STAGES    = 2,
  parameter int SHARED_LO      = 8,
  parameter bit ENABLE_AT_ZERO = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic [NPINS-1:0]  pad_in,
  output logic [NPINS-1:0]  pad_out,
  output logic [NPINS-1:0]  pad_oe,
  output logic              irq_shared
);
  localparam int NSH = NPINS - SHARED_LO;

  logic [NPINS-1:0] pin_sync, dir_q, out_q, ien_q;
  logic [NSH-1:0]   ien_sh;
  logic             clken;

  gpio16_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(pad_in), .q(pin_sync));

  gpio16_regs #(.NPINS(NPINS)) u_regs (
    .clk(clk), .rst(rst), .wr_en(bus_wr), .rd_en(bus_rd), .addr(bus_addr),
    .wdata(bus_wdata), .pin_sync(pin_sync), .dir_q(dir_q), .out_q(out_q),
    .ien_q(ien_q), .clken(clken), .rdata_q(bus_rdata));

  assign ien_sh = ENABLE_AT_ZERO ? ien_q[NSH-1:0] : ien_q[NPINS-1:SHARED_LO];

  gpio16_irq #(.NSH(NSH)) u_irq (
    .clk(clk), .rst(rst), .clken(clken), .pins(pin_sync[NPINS-1:SHARED_LO]),
    .en(ien_sh), .irq(irq_shared));

  assign pad_out = out_q;
  assign pad_oe  = dir_q;
endmodule

// File: tb/gpio16_port_test.sv
module gpio16_port_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [15:0] pad_in = '0;
  logic [31:0] bus_rdata, rdata_lo;
  logic [15:0] pad_out, pad_oe, out_lo, oe_lo;
  logic        irq_shared, irq_lo;

  int    vec = 0, miss = 0;
  bit    done = 1'b0;
  string phase = "R1 reset";

  always #2.5 clk = ~clk;

  gpio16_port uut (.clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .irq_shared(irq_shared));

  gpio16_port #(.ENABLE_AT_ZERO(1'b1)) uut_lo (.clk(clk), .rst(rst), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata_lo),
    .pad_in(pad_in), .pad_out(out_lo), .pad_oe(oe_lo), .irq_shared(irq_lo));

  // behavioural reference model
  logic [15:0] m_dir, m_out, m_ien, m_s1, m_s2;
  logic [1:0]  m_ctl, old_ctl;
  logic [31:0] m_rdata;
  logic        m_irq, m_irq_lo;

  initial begin
    m_dir = 0; m_out = 0; m_ien = 0; m_s1 = 0; m_s2 = 0;
    m_ctl = 0; m_rdata = 0; m_irq = 0; m_irq_lo = 0;
  end

  always @(posedge clk) begin
    if (rst) begin
      m_dir = 0; m_out = 0; m_ien = 0; m_s1 = 0; m_s2 = 0;
      m_ctl = 0; m_rdata = 0; m_irq = 0; m_irq_lo = 0;
    end else begin
      m_rdata = 0;
      if (bus_rd) begin
        if (bus_addr == 5'h00)      m_rdata = {16'h0, m_dir};
        else if (bus_addr == 5'h0C) m_rdata = {16'h0, (m_ctl[0] ? m_s2 : 16'h0)};
        else if (bus_addr == 5'h10) m_rdata = {16'h0, m_ien};
        else if (bus_addr == 5'h14) m_rdata = {30'h0, m_ctl};
      end
      m_irq    = m_ctl[0] && ((m_s2[15:8] & m_ien[15:8]) != 0);
      m_irq_lo = m_ctl[0] && ((m_s2[15:8] & m_ien[7:0])  != 0);
      m_s2 = m_s1;
      m_s1 = pad_in;
      old_ctl = m_ctl;
      if (bus_wr && bus_addr == 5'h14) m_ctl = bus_wdata[1:0];
      if (old_ctl[1]) begin
        m_dir = 0; m_out = 0; m_ien = 0;
      end else if (old_ctl[0] && bus_wr) begin
        if (bus_addr == 5'h00) m_dir = bus_wdata[15:0];
        if (bus_addr == 5'h08)
          for (int i = 0; i < 16; i++) if (bus_wdata[16+i]) m_out[i] = bus_wdata[i];
        if (bus_addr == 5'h10) m_ien = bus_wdata[15:0];
      end
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      vec++;
      if (pad_out !== m_out) begin
        miss++; $display("FAIL %s (R2) pad_out got %h exp %h", phase, pad_out, m_out);
      end
      if (pad_oe !== m_dir) begin
        miss++; $display("FAIL %s (R3) pad_oe got %h exp %h", phase, pad_oe, m_dir);
      end
      if (bus_rdata !== m_rdata) begin
        miss++; $display("FAIL %s (R4) bus_rdata got %h exp %h", phase, bus_rdata, m_rdata);
      end
      if (irq_shared !== m_irq) begin
        miss++; $display("FAIL %s (R5) irq_shared got %b exp %b", phase, irq_shared, m_irq);
      end
      if (irq_lo !== m_irq_lo) begin
        miss++; $display("FAIL %s (R6) irq variant got %b exp %b", phase, irq_lo, m_irq_lo);
      end
    end
  end

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vec, miss);
    $finish;
  endtask

  initial begin
    #(5ns * 100000);
    miss++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    idle(4);
    // R1 reset state is compared every cycle while rst is high and after release
    rst = 1'b0;
    idle(2);
    rd(5'h14); rd(5'h00);

    phase = "R7 bring-up";
    wr(5'h14, 32'h3); wr(5'h14, 32'h1); rd(5'h14);

    phase = "R3 direction";
    wr(5'h00, 32'h0000_A5C3); rd(5'h00);
    wr(5'h00, 32'h0000_FFFF); rd(5'h00);

    phase = "R2 masked output";
    wr(5'h08, 32'hFFFF_1234);
    wr(5'h08, 32'h00F0_FFFF);
    wr(5'h08, 32'h0000_FFFF);
    wr(5'h08, 32'h8001_0000);
    wr(5'h08, 32'h5555_AAAA);

    phase = "R4 pin state";
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      pad_in = 16'h1 << k ^ 16'h3C5A;
      bus_rd = 1'b1; bus_addr = 5'h0C;
    end
    @(negedge clk); bus_rd = 1'b0;
    pad_in = 16'hBEEF; rd(5'h0C); idle(2); rd(5'h0C);

    phase = "R5 shared irq";
    pad_in = 16'h0000;
    wr(5'h10, 32'h0000_FF00); idle(3);
    pad_in = 16'h0100; idle(4);
    pad_in = 16'h00FF; idle(4);
    wr(5'h10, 32'h0000_8000);
    pad_in = 16'h7F00; idle(4);
    pad_in = 16'h8000; idle(4);

    phase = "R6 alternate enable layout";
    pad_in = 16'h0000;
    wr(5'h10, 32'h0000_00FF); idle(3);
    pad_in = 16'h0400; idle(4);
    wr(5'h10, 32'h0000_0001); idle(3);
    pad_in = 16'h0100; idle(4);
    rd(5'h10);

    phase = "R10 write-only and unmapped reads";
    rd(5'h08); rd(5'h04); rd(5'h18); rd(5'h1F); idle(2);

    phase = "R9 clock stopped";
    pad_in = 16'hFF00;
    wr(5'h10, 32'h0000_FF00); idle(3);
    wr(5'h14, 32'h0);
    wr(5'h00, 32'h0000_1111);
    wr(5'h08, 32'hFFFF_0000);
    wr(5'h10, 32'h0000_0000);
    rd(5'h0C); idle(3);
    wr(5'h14, 32'h1);
    rd(5'h00); rd(5'h10); idle(3);

    phase = "R8 soft reset";
    wr(5'h14, 32'h3);
    wr(5'h00, 32'h0000_FFFF);
    wr(5'h08, 32'hFFFF_FFFF);
    rd(5'h00); rd(5'h14);
    wr(5'h14, 32'h1);
    wr(5'h00, 32'h0000_00F0); rd(5'h00);

    phase = "R7 low-power park";
    wr(5'h14, 32'h2); idle(2); rd(5'h14); rd(5'h0C);
    wr(5'h00, 32'h0000_FFFF);
    wr(5'h14, 32'h3); wr(5'h14, 32'h1);
    rd(5'h00); rd(5'h0C);
    wr(5'h08, 32'h0F0F_0F0F);
    idle(4);

    finish_run();
  end
endmodule